// File: doc/BRIEF.md
# Fifth-Order Fixed-Point Lowpass Filter

This block is a fixed-point lowpass IIR filter for audio-rate streams. It is designed for a sample rate of 52 kHz with a -3 dB corner at 1 kHz and a fifth-order maximally flat response. Three direct-form-I sections run one after another: a first-order section, then a lightly resonant biquad, then a strongly resonant biquad. The coefficients are constants built into the design.

A new signed 12-bit sample (Q1.11, zero-centred) is presented together with a one-cycle enable pulse. Each section works in a wide accumulator and rounds only its own result, into a 20-bit Q2.18 state word. The last section's newest result is then rounded and saturated back to Q1.11 on the output. The enable pulses may arrive at any spacing. Between pulses the filter holds its state and its output.

Top module: `lpf_biquad_cascade`

## Requirements
- R1: With a constant input held long enough to settle (600 enable pulses), the output sits within 3 LSB of the input value (unity DC gain).
- R2: Section state and the output change only on clock edges where `en` is high and `rst` is low. Any value on `x_i` while `en` is low has no effect on the output, now or later.
- R3: A synchronous `rst` clears every section register to zero, so the output reads 0 on the cycle after reset. Reset wins over a coincident enable. With zero input after reset, the output stays 0.
- R4: On each enable, every section k computes acc = b0·x + b1·x1 + b2·x2 − 16·(a1·y1 + a2·y2). The input x and the state words are Q2.18. The numerator coefficients are Q.18 and the denominator coefficients are Q.14, so the denominator terms are aligned by a factor of 16. Section 0 takes the input shifted left by 7. Section k>0 takes the registered result that section k−1 held before the same edge. The output is derived from section 2's newest result. The integer coefficients (b0,b1,b2,a1,a2) are: section 0 (14952,14952,0,−14515,0); section 1 (871,1742,871,−29639,13473); section 2 (921,1842,921,−31361,15207). The output matches this recurrence bit for bit.
- R5: Quantisation rounds to nearest with halves going up, by adding half an LSB and then shifting arithmetically. A section result is the accumulator shifted by 18 and clamped to [−2^19, 2^19−1]. The output is the section 2 result shifted by 7 and clamped to [−2048, 2047]. A full-scale step from −2048 to +2047 clips the overshoot at 2047 and never wraps to a negative value.
- R6: A 200 Hz sine of amplitude 1600 comes out with a steady-state peak of at least 1500.
- R7: A 2000 Hz sine of amplitude 1600 comes out with a steady-state peak of at most 110. A 1500 Hz sine of the same amplitude peaks at no more than 300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all filter state |
| en | input | 1 | Sample strobe; the filter advances one sample when high |
| x_i | input | 12 | Signed Q1.11 input sample, zero-centred |
| y_o | output | 12 | Signed Q1.11 filtered sample, rounded and saturated |

## Verification
An input or history word that is captured wrongly in the last section shows on `y_o` right after the enable that uses it. A fault in the first or middle section needs one or two more enable pulses to reach the output, because each section boundary is a register. Faults in the resonant biquad's output history build up over many samples as a gain or ringing error. Comparing every output sample against an integer reference of the recurrence therefore catches any state fault within at most three enables. The DC and sine-amplitude checks expose coefficient or alignment errors that a short run might hide.

// File: rtl/lpf_pkg.sv
package lpf_pkg;

    localparam int COEF_W       = 16;
    localparam int NUM_FRAC     = 18;
    localparam int DEN_FRAC     = 14;
    localparam int NUM_SECTIONS = 3;

    typedef struct packed {
        logic [COEF_W-1:0] b0;
        logic [COEF_W-1:0] b1;
        logic [COEF_W-1:0] b2;
        logic [COEF_W-1:0] a1;
        logic [COEF_W-1:0] a2;
    } coef_set_t;

    // Section order: first-order pole, low-Q pair, high-Q pair.
    function automatic coef_set_t section_coefs(input int idx);
        coef_set_t c;
        case (idx)
            0: begin
                c.b0 = COEF_W'(14952);  c.b1 = COEF_W'(14952);  c.b2 = COEF_W'(0);
                c.a1 = COEF_W'(-14515); c.a2 = COEF_W'(0);
            end
            1: begin
                c.b0 = COEF_W'(871);    c.b1 = COEF_W'(1742);   c.b2 = COEF_W'(871);
                c.a1 = COEF_W'(-29639); c.a2 = COEF_W'(13473);
            end
            default: begin
                c.b0 = COEF_W'(921);    c.b1 = COEF_W'(1842);   c.b2 = COEF_W'(921);
                c.a1 = COEF_W'(-31361); c.a2 = COEF_W'(15207);
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpf_requant.sv
module lpf_requant #(
    parameter int IN_W  = 44,
    parameter int OUT_W = 20,
    parameter int SHIFT = 18
) (
    input  logic signed [IN_W-1:0]  v_i,
    output logic signed [OUT_W-1:0] v_o
);

    localparam int SUM_W = IN_W + 1;
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (SHIFT - 1);
    localparam logic signed [SUM_W-1:0] OMAX =
        {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] OMIN = ~OMAX;

    logic signed [SUM_W-1:0] sum_w;
    logic signed [SUM_W-1:0] shr_w;

    always_comb begin
        sum_w = $signed({v_i[IN_W-1], v_i}) + HALF;
        shr_w = sum_w >>> SHIFT;
        if (shr_w > OMAX) begin
            v_o = OMAX[OUT_W-1:0];
        end else if (shr_w < OMIN) begin
            v_o = OMIN[OUT_W-1:0];
        end else begin
            v_o = shr_w[OUT_W-1:0];
        end
    end

    always_comb begin
        assert (v_o[OUT_W-1] == 1'b0 || shr_w < 0 || shr_w > OMAX)
            else $error("AST_SAT_SIGN: requantised value changed sign"); // R5
    end

endmodule

// File: rtl/lpf_sos_section.sv
module lpf_sos_section #(
    parameter int                 STATE_W = 20,
    parameter lpf_pkg::coef_set_t CF      = '0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic signed [STATE_W-1:0] x_i,
    output logic signed [STATE_W-1:0] y_o
);

    localparam int COEF_W    = lpf_pkg::COEF_W;
    localparam int NUM_FRAC  = lpf_pkg::NUM_FRAC;
    localparam int DEN_SHIFT = lpf_pkg::NUM_FRAC - lpf_pkg::DEN_FRAC;
    localparam int ACC_W     = STATE_W + COEF_W + DEN_SHIFT + 3;

    localparam logic signed [ACC_W-1:0] K_B0 = ACC_W'($signed(CF.b0));
    localparam logic signed [ACC_W-1:0] K_B1 = ACC_W'($signed(CF.b1));
    localparam logic signed [ACC_W-1:0] K_B2 = ACC_W'($signed(CF.b2));
    localparam logic signed [ACC_W-1:0] K_A1 = ACC_W'($signed(CF.a1));
    localparam logic signed [ACC_W-1:0] K_A2 = ACC_W'($signed(CF.a2));

    typedef struct packed {
        logic signed [STATE_W-1:0] x1;
        logic signed [STATE_W-1:0] x2;
        logic signed [STATE_W-1:0] y1;
        logic signed [STATE_W-1:0] y2;
    } sec_state_t;

    sec_state_t st_d, st_q;

    logic signed [ACC_W-1:0]   num_w;
    logic signed [ACC_W-1:0]   den_w;
    logic signed [ACC_W-1:0]   acc_w;
    logic signed [STATE_W-1:0] y_new;

    always_comb begin
        num_w = ACC_W'(x_i) * K_B0
              + ACC_W'(st_q.x1) * K_B1
              + ACC_W'(st_q.x2) * K_B2;
        den_w = ACC_W'(st_q.y1) * K_A1
              + ACC_W'(st_q.y2) * K_A2;
        acc_w = num_w - (den_w <<< DEN_SHIFT);
    end

    lpf_requant #(
        .IN_W  (ACC_W),
        .OUT_W (STATE_W),
        .SHIFT (NUM_FRAC)
    ) u_quant (
        .v_i (acc_w),
        .v_o (y_new)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.x1 = x_i;
            st_d.x2 = st_q.x1;
            st_d.y1 = y_new;
            st_d.y2 = st_q.y1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_o = st_q.y1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (st_q == '0)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!en && !rst) |=> $stable(st_q)); // R2
    AST_Y_HISTORY: assert property (@(posedge clk) disable iff (rst)
        (en && !rst) |=> (st_q.y2 == $past(st_q.y1))); // R4
    AST_X_HISTORY: assert property (@(posedge clk) disable iff (rst)
        (en && !rst) |=> (st_q.x2 == $past(st_q.x1))); // R4

endmodule

// File: rtl/lpf_biquad_cascade.sv
module lpf_biquad_cascade #(
    parameter int DATA_W     = 12,
    parameter int DATA_FRAC  = 11,
    parameter int STATE_W    = 20,
    parameter int STATE_FRAC = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] x_i,
    output logic signed [DATA_W-1:0] y_o
);

    localparam int NSEC  = lpf_pkg::NUM_SECTIONS;
    localparam int ALIGN = STATE_FRAC - DATA_FRAC;

    logic signed [STATE_W-1:0] link [NSEC+1];

    assign link[0] = STATE_W'(x_i) <<< ALIGN;

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        lpf_sos_section #(
            .STATE_W (STATE_W),
            .CF      (lpf_pkg::section_coefs(k))
        ) u_sec (
            .clk (clk),
            .rst (rst),
            .en  (en),
            .x_i (link[k]),
            .y_o (link[k+1])
        );
    end

    lpf_requant #(
        .IN_W  (STATE_W),
        .OUT_W (DATA_W),
        .SHIFT (ALIGN)
    ) u_out (
        .v_i (link[NSEC]),
        .v_o (y_o)
    );

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!en && !rst) |=> $stable(y_o)); // R2
    AST_OUT_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (y_o == '0)); // R3

endmodule

// File: tb/lpf_biquad_cascade_tb.sv
module lpf_biquad_cascade_tb;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic signed [11:0] din = '0;
    logic signed [11:0] dout;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    lpf_biquad_cascade u_dut (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .x_i (din),
        .y_o (dout)
    );

    // Reference recurrence from R4/R5
    longint cb0 [3] = '{14952, 871, 921};
    longint cb1 [3] = '{14952, 1742, 1842};
    longint cb2 [3] = '{0, 871, 921};
    longint ca1 [3] = '{-14515, -29639, -31361};
    longint ca2 [3] = '{0, 13473, 15207};
    longint mx1 [3];
    longint mx2 [3];
    longint my1 [3];
    longint my2 [3];

    function automatic longint rq(input longint v, input int sh, input int w);
        longint r, hi, lo;
        r  = (v + (longint'(1) <<< (sh - 1))) >>> sh;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        return r;
    endfunction

    function automatic void model_clear();
        for (int k = 0; k < 3; k++) begin
            mx1[k] = 0; mx2[k] = 0; my1[k] = 0; my2[k] = 0;
        end
    endfunction

    function automatic int model_step(input int x);
        longint xin [3];
        longint ynew [3];
        longint acc;
        xin[0] = longint'(x) * 128;
        xin[1] = my1[0];
        xin[2] = my1[1];
        for (int k = 0; k < 3; k++) begin
            acc = cb0[k] * xin[k] + cb1[k] * mx1[k] + cb2[k] * mx2[k]
                - 16 * (ca1[k] * my1[k] + ca2[k] * my2[k]);
            ynew[k] = rq(acc, 18, 20);
        end
        for (int k = 0; k < 3; k++) begin
            mx2[k] = mx1[k]; mx1[k] = xin[k];
            my2[k] = my1[k]; my1[k] = ynew[k];
        end
        return int'(rq(my1[2], 7, 12));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One sample: enable pulse, compare with model (R4), then two idle
    // cycles with junk on din that must not move the output (R2).
    task automatic push(input int x, output int got);
        int exp;
        @(negedge clk);
        din = 12'(x);
        en  = 1'b1;
        exp = model_step(x);
        @(negedge clk);
        en  = 1'b0;
        got = int'(dout);
        chk(got == exp, "R4", got, exp);
        for (int i = 0; i < 2; i++) begin
            din = 12'(x ^ 12'h5A5 ^ i);
            @(negedge clk);
            chk(int'(dout) == got, "R2", int'(dout), got);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        chk(dout == 0, "R3", int'(dout), 0);
    endtask

    function automatic int sine(input real amp, input int f, input int n);
        return $rtoi($floor(amp * $sin(2.0 * 3.14159265358979 * f * n / 52000.0) + 0.5));
    endfunction

    task automatic t_dc_gain();
        int got;
        do_reset();
        for (int n = 0; n < 600; n++) push(1000, got);
        chk(got >= 997 && got <= 1003, "R1", got, 1000);
        for (int n = 0; n < 600; n++) push(-700, got);
        chk(got >= -703 && got <= -697, "R1", got, -700);
    endtask

    task automatic t_idle_ignore();
        int got, held;
        do_reset();
        for (int n = 0; n < 40; n++) push(1200, got);
        held = got;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            din = 12'(i * 311 - 2000);
        end
        chk(int'(dout) == held, "R2", int'(dout), held);
        // next pushes still match a model that never saw the junk (R2)
        for (int n = 0; n < 10; n++) push(1200, got);
    endtask

    task automatic t_sweep();
        int got;
        int freqs [14] = '{50, 100, 150, 200, 250, 300, 500, 600, 700, 800,
                           1000, 1200, 1500, 2000};
        do_reset();
        foreach (freqs[i]) begin
            for (int n = 0; n <= 52000 / freqs[i]; n++) push(sine(1800.0, freqs[i], n), got);
        end
    endtask

    task automatic t_passband();
        int got, pk;
        do_reset();
        pk = 0;
        for (int n = 0; n < 520; n++) begin
            push(sine(1600.0, 200, n), got);
            if (n >= 260 && (got > pk || -got > pk)) pk = (got < 0) ? -got : got;
        end
        chk(pk >= 1500, "R6", pk, 1500);
    endtask

    task automatic t_stopband(input int f, input int lim);
        int got, pk;
        do_reset();
        pk = 0;
        for (int n = 0; n < 520; n++) begin
            push(sine(1600.0, f, n), got);
            if (n >= 260 && (got > pk || -got > pk)) pk = (got < 0) ? -got : got;
        end
        chk(pk <= lim, "R7", pk, lim);
    endtask

    task automatic t_saturate();
        int got, mx;
        bit high_seen, wrapped;
        do_reset();
        for (int n = 0; n < 500; n++) push(-2048, got);
        mx = -4096; high_seen = 0; wrapped = 0;
        for (int n = 0; n < 300; n++) begin
            push(2047, got);
            if (got > mx) mx = got;
            if (got >= 1900) high_seen = 1;
            if (high_seen && got < 1000) wrapped = 1;
        end
        chk(mx == 2047, "R5", mx, 2047);
        chk(!wrapped, "R5", int'(wrapped), 0);
    endtask

    task automatic t_reset_priority();
        int got;
        do_reset();
        for (int n = 0; n < 30; n++) push(1500, got);
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        din = 12'sd1500;
        @(negedge clk);
        rst = 1'b0;
        en  = 1'b0;
        model_clear();
        chk(dout == 0, "R3", int'(dout), 0);
        for (int n = 0; n < 20; n++) begin
            push(0, got);
            chk(got == 0, "R3", got, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(dout == 0, "R3", int'(dout), 0);
        t_dc_gain();
        t_idle_ignore();
        t_sweep();
        t_passband();
        t_stopband(2000, 110);
        t_stopband(1500, 300);
        t_saturate();
        t_reset_priority();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule